// File: doc/BRIEF.md
# Inter-processor interrupt cause mapper

This block holds one 16-bit interrupt cause register for each core of a multi-core cluster. Software on any core raises an inter-processor interrupt by writing to one of sixteen set addresses, one per cause bit. The data word of that write selects the target cores. A core acknowledges its interrupts by writing ones to its own cause address, which clears those bits.

Each core has three interrupt lines that drive bits 0 to 2 of its interrupt vector. The cause bits fall into four fixed groups: bit 0, bits 1 to 3, bits 4 to 7 and bits 8 to 15. Each group raises the OR of its bits. A shared 8-bit partition register gives each group a 2-bit field that names the line the group drives. A group steered to line 3 reaches no output.

There are two write ports, so two masters can write in the same cycle. A single read port returns cause registers and the partition register combinationally. Register updates take effect at the write clock edge. The lines follow the registers combinationally.

Top module: `ipi_cause_mapper`

## Requirements
- R1: After reset every cause register, the partition register and every interrupt line read 0.
- R2: A write of data D to address 0x140+k (k from 0 to 15) sets cause bit k in each core c whose D bit c is 1. It leaves every other bit unchanged.
- R3: A write of data D to address 0x100+c clears the bits of core c's cause register where D is 1. The other bits of that register are kept.
- R4: Reading address 0x100+c returns core c's cause register. Cause addresses up to 0x13F that name no implemented core read 0, and writes to them change nothing. Reads of other unmapped addresses return 0.
- R5: Line L of a core is 1 when at least one group of that core with a nonzero OR has its partition field equal to L. The group fields sit at partition bits [1:0] for bit 0, [3:2] for bits 1-3, [5:4] for bits 4-7 and [7:6] for bits 8-15.
- R6: A group whose partition field is 3 drives no line, so a partition value of 0xFF holds every line low.
- R7: A write to address 0x180 replaces the whole partition register with data bits [7:0]. The register reads back at that address. If both ports write it in the same cycle, port 1's value is kept.
- R8: If a set and a clear of the same bit of the same core arrive in one cycle, on either port combination, the bit ends up set.
- R9: A register write changes the read data and the interrupt lines from the clock edge that accepts it, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NPORT | Write strobe per port |
| wr_addr | input | NPORT*AW | Write address per port, port p in bits [p*AW +: AW] |
| wr_data | input | NPORT*16 | Write data per port, port p in bits [p*16 +: 16] |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Read data for rd_addr |
| core_irq | output | NCORE*3 | Interrupt lines, core c in bits [c*3 +: 3] |

## Verification
The hardest case to reach is a cycle in which both ports hit the same core at once: one port sets a cause bit while the other clears it, or both write the partition register. Reaching it requires both ports to fire in the same cycle with matching targets. Directed phases put a set on one port and a clearing write on the other in the same cycle, in both port orders. A long random phase then draws both ports from a small address pool so that collisions recur. Throughout, a behavioural model is compared with the lines and the read data on every clock.

// File: rtl/ipi_cause_mapper.sv
module ipi_cause_mapper #(
  parameter int NCORE = 4,
  parameter int NPORT = 2,
  parameter int AW    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORT-1:0]     wr_en,
  input  logic [NPORT*AW-1:0]  wr_addr,
  input  logic [NPORT*16-1:0]  wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [15:0]          rd_data,
  output logic [NCORE*3-1:0]   core_irq
);
  localparam logic [AW-1:0] CAUSE_BASE = AW'(10'h100);
  localparam logic [AW-1:0] SET_BASE   = AW'(10'h140);
  localparam logic [AW-1:0] PART_ADDR  = AW'(10'h180);
  localparam int            NGRP       = 4;
  localparam int            NLINE      = 3;

  logic [NCORE-1:0][15:0] cause_q, set_m, clr_m;
  logic [7:0]             part_q, part_d;
  logic                   part_we;

  always_comb begin
    set_m   = '0;
    clr_m   = '0;
    part_d  = part_q;
    part_we = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (wr_en[p]) begin
        for (int c = 0; c < NCORE; c++) begin
          if (wr_addr[p*AW +: AW] == CAUSE_BASE + AW'(c))
            clr_m[c] = clr_m[c] | wr_data[p*16 +: 16];
          if (wr_addr[p*AW+4 +: AW-4] == SET_BASE[AW-1:4] && wr_data[p*16+c])
            set_m[c][wr_addr[p*AW +: 4]] = 1'b1;
        end
        if (wr_addr[p*AW +: AW] == PART_ADDR) begin
          part_d  = wr_data[p*16 +: 8];
          part_we = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      part_q  <= '0;
    end else begin
      for (int c = 0; c < NCORE; c++)
        cause_q[c] <= (cause_q[c] & ~clr_m[c]) | set_m[c];
      if (part_we) part_q <= part_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCORE; c++)
      if (rd_addr == CAUSE_BASE + AW'(c)) rd_data = cause_q[c];
    if (rd_addr == PART_ADDR) rd_data = {8'h00, part_q};
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [NGRP-1:0]  grp;
    logic [NLINE-1:0] ln;
    assign grp[0] = cause_q[c][0];
    assign grp[1] = |cause_q[c][3:1];
    assign grp[2] = |cause_q[c][7:4];
    assign grp[3] = |cause_q[c][15:8];

    for (genvar l = 0; l < NLINE; l++) begin : g_line
      logic [NGRP-1:0] hit;
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign hit[g] = grp[g] && (part_q[2*g +: 2] == 2'(l));
      end
      assign ln[l] = |hit;
    end
    assign core_irq[c*3 +: 3] = ln;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_m[c] != 0) |=> ((cause_q[c] & $past(set_m[c])) == $past(set_m[c])));
    a_r3_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_m[c] & ~set_m[c]) != 0) |=> ((cause_q[c] & $past(clr_m[c] & ~set_m[c])) == 0));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_m[c] == 0 && set_m[c] == 0) |=> $stable(cause_q[c]));
    a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q[c] == 0) |-> (core_irq[c*3 +: 3] == 3'b000));
  end

  a_r6_all_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (part_q == 8'hFF) |-> (core_irq == '0));
  a_r7_part_load: assert property (@(posedge clk) disable iff (!rst_n)
    part_we |=> (part_q == $past(part_d)));
  a_r7_part_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !part_we |=> $stable(part_q));
endmodule

// File: tb/ipi_cause_mapper_test.sv
module ipi_cause_mapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NP = 2;
  localparam int AW = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     wr_en = '0;
  logic [NP*AW-1:0]  wr_addr = '0;
  logic [NP*16-1:0]  wr_data = '0;
  logic [AW-1:0]     rd_addr = '0;
  logic [15:0]       rd_data;
  logic [NC*3-1:0]   core_irq;

  int n_checks = 0, n_fail = 0;
  string phase = "R1";
  logic [15:0] m_cause [NC];
  logic [7:0]  m_part;

  ipi_cause_mapper #(.NCORE(NC), .NPORT(NP), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .core_irq(core_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    logic [15:0] nc [NC];
    logic [7:0]  np;
    np = m_part;
    for (int c = 0; c < NC; c++) nc[c] = m_cause[c];
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) nc[c] = 16'h0;
      np = 8'h00;
    end else begin
      for (int p = 0; p < NP; p++)
        if (wr_en[p] && int'(wr_addr[p*AW +: AW]) >= 'h100 && int'(wr_addr[p*AW +: AW]) < 'h100 + NC)
          nc[int'(wr_addr[p*AW +: AW]) - 'h100] &= ~wr_data[p*16 +: 16];
      for (int p = 0; p < NP; p++)
        if (wr_en[p] && int'(wr_addr[p*AW +: AW]) >= 'h140 && int'(wr_addr[p*AW +: AW]) < 'h150)
          for (int c = 0; c < NC; c++)
            if (wr_data[p*16 + c]) nc[c][int'(wr_addr[p*AW +: AW]) - 'h140] = 1'b1;
      for (int p = 0; p < NP; p++)
        if (wr_en[p] && wr_addr[p*AW +: AW] == 10'h180) np = wr_data[p*16 +: 8];
    end
    for (int c = 0; c < NC; c++) m_cause[c] <= nc[c];
    m_part <= np;
  end

  function automatic logic [2:0] model_lines(logic [15:0] cv, logic [7:0] pv);
    logic [3:0] act;
    logic [2:0] res;
    act = {cv[15:8] != 0, cv[7:4] != 0, cv[3:1] != 0, cv[0]};
    res = 3'b000;
    for (int g = 0; g < 4; g++)
      if (act[g] && pv[2*g +: 2] != 2'd3) res[pv[2*g +: 2]] = 1'b1;
    return res;
  endfunction

  function automatic logic [15:0] model_read(logic [AW-1:0] a);
    if (int'(a) >= 'h100 && int'(a) < 'h100 + NC) return m_cause[int'(a) - 'h100];
    if (a == 10'h180) return {8'h00, m_part};
    return 16'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare();
    for (int c = 0; c < NC; c++)
      check({phase, "/R5 lines"}, 32'(core_irq[c*3 +: 3]), 32'(model_lines(m_cause[c], m_part)));
    check({phase, "/R4 read"}, 32'(rd_data), 32'(model_read(rd_addr)));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    wr_en = '0;
  endtask

  task automatic wr(int p, int a, int d);
    wr_en[p] = 1'b1;
    wr_addr[p*AW +: AW] = AW'(a);
    wr_data[p*16 +: 16] = 16'(d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    phase = "R1";
    for (int a = 0; a < NC; a++) begin rd_addr = AW'('h100 + a); tick(); end
    rd_addr = 10'h180; tick();
    check("R1 reset lines", 32'(core_irq), 32'h0);

    phase = "R2";
    rd_addr = 10'h101;
    wr(0, 'h140, 'h3); tick();
    wr(1, 'h145, 'h2); tick();
    wr(0, 'h14F, 'hFFFF); tick();
    check("R2 core1 cause", 32'(rd_data), 32'h8021);

    phase = "R3";
    wr(0, 'h101, 'h0020); tick();
    check("R3 core1 partial clear", 32'(rd_data), 32'h8001);
    rd_addr = 10'h100;
    wr(1, 'h100, 'hFFFF); tick();

    phase = "R4";
    rd_addr = 10'h104; wr(0, 'h104, 'hFFFF); tick();
    check("R4 unimplemented read", 32'(rd_data), 32'h0);
    rd_addr = 10'h13F; tick();
    rd_addr = 10'h0FF; tick();

    phase = "R5";
    for (int k = 0; k < 16; k++) begin
      wr(0, 'h100 + (k % NC), 'hFFFF); tick();
      wr(1, 'h140 + k, 1 << (k % NC)); tick();
      for (int pv = 0; pv < 8; pv++) begin
        wr(0, 'h180, (pv * 37 + k * 11) & 'hFF); rd_addr = AW'('h100 + (k % NC)); tick();
      end
    end

    phase = "R6";
    wr(0, 'h14A, 'hF); wr(1, 'h180, 'hFF); tick();
    check("R6 all groups dropped", 32'(core_irq), 32'h0);
    wr(0, 'h180, 'h3F); tick();

    phase = "R7";
    rd_addr = 10'h180;
    wr(0, 'h180, 'h12); wr(1, 'h180, 'hE4); tick();
    check("R7 port1 wins", 32'(rd_data), 32'h00E4);
    wr(1, 'h180, 'hAB5C); tick();
    check("R7 replace low byte", 32'(rd_data), 32'h005C);

    phase = "R8";
    rd_addr = 10'h102;
    wr(0, 'h102, 'hFFFF); tick();
    wr(0, 'h143, 'h4); wr(1, 'h102, 'hFFFF); tick();
    check("R8 set beats clear p0", 32'(rd_data), 32'h0008);
    wr(1, 'h147, 'h4); wr(0, 'h102, 'h0088); tick();
    check("R8 set beats clear p1", 32'(rd_data), 32'h0080);

    phase = "R9";
    wr(0, 'h180, 'h00); wr(1, 'h102, 'hFFFF); tick();
    wr(0, 'h140, 'h4); tick();
    check("R9 same-edge line", 32'(core_irq[6 +: 3]), 32'h1);

    phase = "RND";
    for (int i = 0; i < 600; i++) begin
      for (int p = 0; p < NP; p++) begin
        int sel;
        sel = int'($urandom_range(0, 9));
        if ($urandom_range(0, 3) != 0) begin
          if (sel < 4)      wr(p, 'h100 + int'($urandom_range(0, 5)), int'($urandom_range(0, 'hFFFF)));
          else if (sel < 9) wr(p, 'h140 + int'($urandom_range(0, 15)), int'($urandom_range(0, 'hF)));
          else              wr(p, 'h180, int'($urandom_range(0, 'hFF)));
        end
      end
      rd_addr = ($urandom_range(0, 4) == 0) ? 10'h180 : AW'('h100 + int'($urandom_range(0, 4)));
      tick();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule